// File: doc/BRIEF.md
# Retirement Debug Event Detector

This block watches the instruction retirement stage and recognises three debug events: a trap instruction whose condition is met, a branch that is taken, and the completion of any instruction. Each event has its own enable. The machine debug-enable bit gates each event in a different way. Traps are recorded whatever that bit holds. Taken branches and completions are recorded only while it is set.

A recognised event sets a sticky status bit. Software or debug logic clears these bits through a write-one-to-clear port. A taken-branch event also stores the address of the branch instruction in a save register. While any status bit is set, the block holds a debug-exception request high. Pipeline control and interrupt vectoring lie outside this block.

Top module: `dbg_retire_events`

## Requirements
- R1: When `rt_valid`, `rt_is_trap`, `rt_trap_cond` and `en_trap` are all 1, `status[0]` is 1 after the next rising clock edge.
- R2: The trap event of R1 is recorded when `msr_dbg_en` is 0 as well as when it is 1.
- R3: When `rt_valid`, `rt_is_branch`, `rt_br_taken`, `en_branch` and `msr_dbg_en` are all 1, `status[1]` is 1 after the next edge. The branch unit reports both unconditional branches and true conditional branches as taken.
- R4: A taken branch retired while `msr_dbg_en` is 0 never sets `status[1]` and leaves `save_addr` unchanged.
- R5: `save_addr` loads `rt_addr` on the edge that records a branch-taken event and holds its value in every other cycle.
- R6: When `rt_valid`, `en_icomp` and `msr_dbg_en` are 1 and the instruction is not suppressed, `status[2]` is 1 after the next edge, whatever the instruction type.
- R7: An instruction with `rt_suppressed` = 1 and `rt_is_syscall` = 0 produces no completion event. A system-call instruction (`rt_is_syscall` = 1) counts as completed even when `rt_suppressed` is 1.
- R8: Status bits are sticky. When `clr_we` is 1, each bit whose `clr_mask` bit is 1 clears on the next edge. If a bit is set by an event in the same cycle, setting wins.
- R9: When several events qualify on one retiring instruction, all of their status bits are set on the same edge.
- R10: Reset clears `status` and `save_addr` to 0. `dbg_req` is 1 exactly when at least one status bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rt_valid | input | 1 | An instruction retires this cycle |
| rt_is_trap | input | 1 | Retiring instruction is a trap instruction |
| rt_is_branch | input | 1 | Retiring instruction is a branch |
| rt_is_syscall | input | 1 | Retiring instruction is a system call |
| rt_trap_cond | input | 1 | Trap condition evaluated true |
| rt_br_taken | input | 1 | Branch is taken (unconditional or condition true) |
| rt_suppressed | input | 1 | Execution suppressed by another enabled exception |
| rt_addr | input | AW | Address of the retiring instruction |
| en_trap | input | 1 | Trap event enable |
| en_branch | input | 1 | Branch-taken event enable |
| en_icomp | input | 1 | Instruction-complete event enable |
| msr_dbg_en | input | 1 | Machine debug-enable bit |
| clr_we | input | 1 | Status clear strobe |
| clr_mask | input | 3 | Status bits to clear (bit 0 trap, bit 1 branch, bit 2 complete) |
| status | output | 3 | Sticky status: bit 0 trap, bit 1 branch taken, bit 2 complete |
| save_addr | output | AW | Address of the last recognised taken branch |
| dbg_req | output | 1 | Debug-exception request |

## Verification
The hardest cases to reach are those where the gating rules and the clear port meet on one edge. Examples are a taken branch retiring with the debug-enable bit low while its status bit is being cleared, and a suppressed system call retiring together with a clear of the completion bit. A long pseudo-random phase reaches many of these overlaps. It biases the clear strobe and the flag inputs so that collisions happen often, and a behavioural model checks every cycle. Directed sequences then build each collision on purpose: they clear the status, drive one chosen instruction and examine the status bits and the save register on the following cycle.

// File: rtl/dbg_evt_pkg.sv
package dbg_evt_pkg;

    localparam int EVT_N = 3;

    typedef struct packed {
        logic valid;
        logic is_trap;
        logic is_branch;
        logic is_syscall;
        logic trap_cond;
        logic br_taken;
        logic suppressed;
    } retire_flags_t;

    typedef struct packed {
        logic en_trap;
        logic en_branch;
        logic en_icomp;
        logic msr_de;
    } evt_ctrl_t;

    // member order gives bit 0 = trap, bit 1 = branch, bit 2 = complete
    typedef struct packed {
        logic icomp;
        logic branch;
        logic trap;
    } evt_vec_t;

    function automatic evt_vec_t detect_events(retire_flags_t f, evt_ctrl_t c);
        evt_vec_t e;
        logic     really_suppressed;
        really_suppressed = f.suppressed & ~f.is_syscall;
        e.trap   = f.valid & f.is_trap & f.trap_cond & c.en_trap;
        e.branch = f.valid & f.is_branch & f.br_taken & c.en_branch & c.msr_de;
        e.icomp  = f.valid & ~really_suppressed & c.en_icomp & c.msr_de;
        return e;
    endfunction

endpackage

// File: rtl/dbg_evt_detect.sv
module dbg_evt_detect
    import dbg_evt_pkg::*;
(
    input  retire_flags_t flags,
    input  evt_ctrl_t     ctrl,
    output evt_vec_t      events
);
    always_comb begin
        events = detect_events(flags, ctrl);
    end
endmodule

// File: rtl/dbg_evt_status.sv
module dbg_evt_status #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_vec,
    input  logic         clr_we,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] status,
    output logic         req
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                status[i] <= 1'b0;
            end else begin
                // a new event outranks a clear of the same bit
                status[i] <= set_vec[i] | (status[i] & ~(clr_we & clr_mask[i]));
            end
        end
    end

    assign req = |status;
endmodule

// File: rtl/dbg_addr_save.sv
module dbg_addr_save #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] addr_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= addr_in;
        end
    end
endmodule

// File: rtl/dbg_retire_events.sv
module dbg_retire_events
    import dbg_evt_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rt_valid,
    input  logic          rt_is_trap,
    input  logic          rt_is_branch,
    input  logic          rt_is_syscall,
    input  logic          rt_trap_cond,
    input  logic          rt_br_taken,
    input  logic          rt_suppressed,
    input  logic [AW-1:0] rt_addr,
    input  logic          en_trap,
    input  logic          en_branch,
    input  logic          en_icomp,
    input  logic          msr_dbg_en,
    input  logic          clr_we,
    input  logic [2:0]    clr_mask,
    output logic [2:0]    status,
    output logic [AW-1:0] save_addr,
    output logic          dbg_req
);
    retire_flags_t flags;
    evt_ctrl_t     ctrl;
    evt_vec_t      events;

    always_comb begin
        flags.valid      = rt_valid;
        flags.is_trap    = rt_is_trap;
        flags.is_branch  = rt_is_branch;
        flags.is_syscall = rt_is_syscall;
        flags.trap_cond  = rt_trap_cond;
        flags.br_taken   = rt_br_taken;
        flags.suppressed = rt_suppressed;
        ctrl.en_trap     = en_trap;
        ctrl.en_branch   = en_branch;
        ctrl.en_icomp    = en_icomp;
        ctrl.msr_de      = msr_dbg_en;
    end

    dbg_evt_detect u_detect (
        .flags  (flags),
        .ctrl   (ctrl),
        .events (events)
    );

    dbg_evt_status #(.N(EVT_N)) u_status (
        .clk      (clk),
        .rst      (rst),
        .set_vec  (events),
        .clr_we   (clr_we),
        .clr_mask (clr_mask),
        .status   (status),
        .req      (dbg_req)
    );

    dbg_addr_save #(.AW(AW)) u_save (
        .clk     (clk),
        .rst     (rst),
        .load    (events.branch),
        .addr_in (rt_addr),
        .addr_q  (save_addr)
    );
endmodule

// File: rtl/dbg_retire_events_chk.sv
module dbg_retire_events_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          rt_valid,
    input logic          rt_is_trap,
    input logic          rt_is_branch,
    input logic          rt_is_syscall,
    input logic          rt_trap_cond,
    input logic          rt_br_taken,
    input logic          rt_suppressed,
    input logic          en_trap,
    input logic          en_branch,
    input logic          en_icomp,
    input logic          msr_dbg_en,
    input logic          clr_we,
    input logic [2:0]    clr_mask,
    input logic [2:0]    status,
    input logic [AW-1:0] save_addr,
    input logic          dbg_req
);
    assert_trap_set_R2: assert property (@(posedge clk) disable iff (rst)
        (rt_valid && rt_is_trap && rt_trap_cond && en_trap) |=> (status[0] && dbg_req));

    assert_branch_gated_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(status[1]) |-> $past(msr_dbg_en && rt_valid && rt_is_branch && rt_br_taken));

    assert_save_only_on_branch_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(save_addr) |-> $past(rt_valid && rt_is_branch && rt_br_taken && en_branch && msr_dbg_en));

    assert_icomp_set_R6: assert property (@(posedge clk) disable iff (rst)
        (rt_valid && en_icomp && msr_dbg_en && !rt_suppressed) |=> status[2]);

    assert_suppressed_no_icomp_R7: assert property (@(posedge clk) disable iff (rst)
        (rt_valid && rt_suppressed && !rt_is_syscall && !status[2]) |=> !status[2]);

    assert_sticky_trap_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(status[0]) |-> $past(clr_we && clr_mask[0]));

    assert_sticky_icomp_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(status[2]) |-> $past(clr_we && clr_mask[2]));

    assert_req_follows_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(dbg_req) |-> $past(rt_valid));
endmodule

bind dbg_retire_events dbg_retire_events_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .rt_valid(rt_valid), .rt_is_trap(rt_is_trap),
    .rt_is_branch(rt_is_branch), .rt_is_syscall(rt_is_syscall),
    .rt_trap_cond(rt_trap_cond), .rt_br_taken(rt_br_taken),
    .rt_suppressed(rt_suppressed), .en_trap(en_trap), .en_branch(en_branch),
    .en_icomp(en_icomp), .msr_dbg_en(msr_dbg_en), .clr_we(clr_we),
    .clr_mask(clr_mask), .status(status), .save_addr(save_addr), .dbg_req(dbg_req)
);

// File: tb/test_dbg_retire_events.sv
module test_dbg_retire_events;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          rt_valid, rt_is_trap, rt_is_branch, rt_is_syscall;
    logic          rt_trap_cond, rt_br_taken, rt_suppressed;
    logic [AW-1:0] rt_addr;
    logic          en_trap, en_branch, en_icomp, msr_dbg_en, clr_we;
    logic [2:0]    clr_mask;
    logic [2:0]    status;
    logic [AW-1:0] save_addr;
    logic          dbg_req;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // reference model state
    bit            m_trap, m_br, m_ic;
    logic [AW-1:0] m_save;
    bit            model_on = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    dbg_retire_events #(.AW(AW)) i_dbg_retire_events (
        .clk(clk), .rst(rst), .rt_valid(rt_valid), .rt_is_trap(rt_is_trap),
        .rt_is_branch(rt_is_branch), .rt_is_syscall(rt_is_syscall),
        .rt_trap_cond(rt_trap_cond), .rt_br_taken(rt_br_taken),
        .rt_suppressed(rt_suppressed), .rt_addr(rt_addr), .en_trap(en_trap),
        .en_branch(en_branch), .en_icomp(en_icomp), .msr_dbg_en(msr_dbg_en),
        .clr_we(clr_we), .clr_mask(clr_mask), .status(status),
        .save_addr(save_addr), .dbg_req(dbg_req)
    );

    task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference, updated on each edge from the applied inputs
    always @(posedge clk) begin
        bit t, b, c;
        if (rst) begin
            m_trap = 0; m_br = 0; m_ic = 0; m_save = '0;
        end else begin
            t = rt_valid && rt_is_trap && rt_trap_cond && en_trap;
            b = rt_valid && rt_is_branch && rt_br_taken && en_branch && msr_dbg_en;
            c = rt_valid && en_icomp && msr_dbg_en && !(rt_suppressed && !rt_is_syscall);
            if (clr_we && clr_mask[0]) m_trap = 0;
            if (clr_we && clr_mask[1]) m_br = 0;
            if (clr_we && clr_mask[2]) m_ic = 0;
            if (t) m_trap = 1;
            if (b) begin m_br = 1; m_save = rt_addr; end
            if (c) m_ic = 1;
        end
    end

    always @(negedge clk) begin
        if (model_on) begin
            check("R1 trap bit",        AW'(status[0]), AW'(m_trap));
            check("R3 branch bit",      AW'(status[1]), AW'(m_br));
            check("R6 complete bit",    AW'(status[2]), AW'(m_ic));
            check("R5 save_addr",       save_addr, m_save);
            check("R10 dbg_req",        AW'(dbg_req), AW'(m_trap | m_br | m_ic));
        end
    end

    task automatic idle();
        rt_valid = 0; rt_is_trap = 0; rt_is_branch = 0; rt_is_syscall = 0;
        rt_trap_cond = 0; rt_br_taken = 0; rt_suppressed = 0; rt_addr = '0;
        clr_we = 0; clr_mask = 3'b000;
    endtask

    task automatic clear_all();
        @(negedge clk);
        idle();
        clr_we = 1; clr_mask = 3'b111;
        @(negedge clk);
        idle();
    endtask

    initial begin
        rst = 1;
        idle();
        en_trap = 0; en_branch = 0; en_icomp = 0; msr_dbg_en = 0;
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 reset status", AW'(status), '0);
        check("R10 reset save",   save_addr, '0);
        check("R10 reset req",    AW'(dbg_req), '0);
        rst = 0;
        model_on = 1'b1;

        // pseudo-random phase, compared every cycle against the model
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            rt_valid      = ($urandom % 4) != 0;
            rt_is_trap    = ($urandom % 3) == 0;
            rt_is_branch  = ($urandom % 3) == 0;
            rt_is_syscall = ($urandom % 5) == 0;
            rt_trap_cond  = $urandom % 2;
            rt_br_taken   = $urandom % 2;
            rt_suppressed = ($urandom % 4) == 0;
            rt_addr       = $urandom;
            en_trap       = ($urandom % 4) != 0;
            en_branch     = ($urandom % 4) != 0;
            en_icomp      = ($urandom % 3) == 0;
            msr_dbg_en    = $urandom % 2;
            clr_we        = ($urandom % 3) == 0;
            clr_mask      = 3'($urandom);
        end

        // directed cases
        en_trap = 1; en_branch = 1; en_icomp = 0; msr_dbg_en = 1;
        clear_all();
        // R3/R5: taken branch with debug enabled
        rt_valid = 1; rt_is_branch = 1; rt_br_taken = 1; rt_addr = 32'h0000_4A10;
        @(negedge clk); idle();
        check("R3 branch recorded", AW'(status[1]), 1);
        check("R5 address captured", save_addr, 32'h0000_4A10);

        // R4: same with debug-enable low, status cleared first
        clear_all();
        msr_dbg_en = 0;
        rt_valid = 1; rt_is_branch = 1; rt_br_taken = 1; rt_addr = 32'hDEAD_0000;
        @(negedge clk); idle();
        check("R4 branch not recorded", AW'(status[1]), 0);
        check("R4 save unchanged", save_addr, 32'h0000_4A10);

        // R2: trap with debug-enable low
        rt_valid = 1; rt_is_trap = 1; rt_trap_cond = 1;
        @(negedge clk); idle();
        check("R2 trap with msr low", AW'(status), 3'b001);

        // R7: suppressed non-syscall gives no completion, syscall does
        msr_dbg_en = 1; en_icomp = 1;
        clear_all();
        rt_valid = 1; rt_suppressed = 1;
        @(negedge clk); idle();
        check("R7 suppressed no complete", AW'(status[2]), 0);
        rt_valid = 1; rt_suppressed = 1; rt_is_syscall = 1;
        @(negedge clk); idle();
        check("R7 syscall completes", AW'(status[2]), 1);

        // R8: partial clear keeps other bits, set beats clear
        rt_valid = 1; rt_is_trap = 1; rt_trap_cond = 1;
        @(negedge clk); idle();
        clr_we = 1; clr_mask = 3'b100;
        @(negedge clk); idle();
        check("R8 partial clear", AW'(status), 3'b001);
        rt_valid = 1; rt_is_trap = 1; rt_trap_cond = 1; clr_we = 1; clr_mask = 3'b001;
        en_icomp = 0;
        @(negedge clk); idle();
        check("R8 set wins over clear", AW'(status), 3'b001);

        // R9: all three events on one instruction
        en_icomp = 1;
        clear_all();
        check("R10 req low when clear", AW'(dbg_req), 0);
        rt_valid = 1; rt_is_trap = 1; rt_trap_cond = 1; rt_is_branch = 1;
        rt_br_taken = 1; rt_addr = 32'h0000_8008;
        @(negedge clk); idle();
        check("R9 all bits together", AW'(status), 3'b111);
        check("R9 save address", save_addr, 32'h0000_8008);
        check("R10 req high", AW'(dbg_req), 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule